// File: doc/BRIEF.md
# Load/Store Port Handshake Monitor

This block passively watches one load/store request port, the link between a unit that issues memory operations and the memory-side buffer that serves them. The handshake is not fire-and-forget. The issuing side raises a single-cycle load or store strobe. Busy then covers the whole transaction. The buffer answers with a one-cycle address accept or address exception. A load finishes when load data valid pulses. A store finishes one cycle after the issuer's store data valid pulse. The monitor drives nothing on the port.

Each clock cycle, the monitor compares the port against an internal phase register with four phases: idle, awaiting address answer, address accepted, and closing. Any breach is latched into a sticky error flag and a one-hot error code. The code records only the first breach seen after the synchronous reset. If several rules break in the same cycle, the lowest-numbered code bit wins. The address width is a parameter.

Top module: `ldst_port_checker`

## Requirements
- R1: A cycle where the load and store strobes are both high sets code bit 0.
- R2: A load or store strobe in a cycle where busy is high sets code bit 1.
- R3: Code bit 2 is set if busy is low in the cycle right after a request is taken from idle, unless an address exception arrives in that cycle. It is also set if busy is high in idle with no request present.
- R4: Code bit 3 covers the end of a transaction. Busy must be low in the cycle of an address exception and in the cycle of load data valid. Busy must be high in the cycle of store data valid and low in the cycle after it. Busy must not fall at any other point of a transaction.
- R5: After a cycle with both address valid and busy high, code bit 4 is set if busy is still high but address valid has dropped or the address value has changed.
- R6: Code bit 5 is set in any of these cases: address accept and address exception are high together; either is high outside the awaiting phase; either is high for two cycles in a row; either is high a second time in one transaction.
- R7: Load data valid or store data valid high in two consecutive cycles sets code bit 6.
- R8: A load or store data valid pulse before the address accept of its transaction sets code bit 7.
- R9: Code bit 8 is set by load data valid in a store transaction, by store data valid in a load transaction, and by either data valid outside a transaction.
- R10: Reset clears the flag and the code. Once set, the flag stays high and the code stays unchanged until the next reset. When several bits break together, only the lowest-numbered one is recorded.
- R11: Well-formed load, store and exception transactions leave the flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_req | input | 1 | Load request strobe |
| st_req | input | 1 | Store request strobe |
| busy | input | 1 | Transaction in progress |
| addr_vld | input | 1 | Address value is valid |
| addr | input | ADDR_W | Address value |
| addr_ack | input | 1 | Address accepted pulse |
| addr_exc | input | 1 | Address exception pulse |
| ld_vld | input | 1 | Load data valid pulse |
| st_vld | input | 1 | Store data valid pulse |
| err | output | 1 | Sticky error flag |
| err_code | output | 9 | One-hot code of the first breach |

## Verification
A breach is detected combinationally in the cycle it occurs. It is registered at that cycle's closing clock edge, so the flag and code show it one cycle after the offending stimulus. The bench changes inputs one time unit after a rising edge, waits for the next rising edge, and samples one time unit later. The store-close rule is judged in the cycle after the store data pulse, so that case is sampled one cycle later than the others. Each breach scenario starts from a fresh reset, which keeps the expected code equal to the single bit under test.

// File: rtl/ldst_chk_pkg.sv
package ldst_chk_pkg;
  typedef enum logic [1:0] {
    PH_IDLE     = 2'd0,
    PH_WAIT_ACK = 2'd1,
    PH_ACKED    = 2'd2,
    PH_CLOSE    = 2'd3
  } phase_e;

  localparam int NUM_RULES   = 9;
  localparam int RB_BOTH_REQ = 0;
  localparam int RB_REQ_BUSY = 1;
  localparam int RB_BUSY_UP  = 2;
  localparam int RB_BUSY_END = 3;
  localparam int RB_ADDR     = 4;
  localparam int RB_ANSWER   = 5;
  localparam int RB_PULSE    = 6;
  localparam int RB_EARLY    = 7;
  localparam int RB_KIND     = 8;
endpackage

// File: rtl/ldst_phase_tracker.sv
module ldst_phase_tracker
  import ldst_chk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld_req,
  input  logic                 st_req,
  input  logic                 busy,
  input  logic                 addr_ack,
  input  logic                 addr_exc,
  input  logic                 ld_vld,
  input  logic                 st_vld,
  output logic [NUM_RULES-1:0] viol
);
  phase_e phase_q, phase_d;
  logic   is_st_q;
  logic   first_q;
  logic   ld_vld_q, st_vld_q;

  logic req, any_vld, proper_end, in_txn;

  always_comb begin
    req        = ld_req | st_req;
    any_vld    = ld_vld | st_vld;
    in_txn     = (phase_q == PH_WAIT_ACK) || (phase_q == PH_ACKED);
    proper_end = ((phase_q == PH_WAIT_ACK) && addr_exc) ||
                 ((phase_q == PH_ACKED) && !is_st_q && ld_vld);

    viol = '0;
    viol[RB_BOTH_REQ] = ld_req & st_req;
    viol[RB_REQ_BUSY] = req & busy;
    viol[RB_BUSY_UP]  = ((phase_q == PH_IDLE) && busy && !req) ||
                        ((phase_q == PH_WAIT_ACK) && first_q && !busy && !addr_exc);
    viol[RB_BUSY_END] = (in_txn && !busy && !proper_end &&
                         !((phase_q == PH_WAIT_ACK) && first_q)) ||
                        (proper_end && busy) ||
                        ((phase_q == PH_CLOSE) && busy);
    viol[RB_ANSWER]   = (addr_ack & addr_exc) ||
                        ((addr_ack | addr_exc) && (phase_q != PH_WAIT_ACK));
    viol[RB_PULSE]    = (ld_vld & ld_vld_q) | (st_vld & st_vld_q);
    viol[RB_EARLY]    = (phase_q == PH_WAIT_ACK) && any_vld;
    viol[RB_KIND]     = (((phase_q == PH_IDLE) || (phase_q == PH_CLOSE)) && any_vld) ||
                        ((phase_q == PH_ACKED) &&
                         ((is_st_q && ld_vld) || (!is_st_q && st_vld)));
  end

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:     if (req) phase_d = PH_WAIT_ACK;
      PH_WAIT_ACK: begin
        if (addr_exc)      phase_d = PH_IDLE;
        else if (addr_ack) phase_d = PH_ACKED;
        else if (!busy)    phase_d = PH_IDLE;
      end
      PH_ACKED: begin
        if (!is_st_q && ld_vld)     phase_d = PH_IDLE;
        else if (is_st_q && st_vld) phase_d = PH_CLOSE;
        else if (!busy)             phase_d = PH_IDLE;
      end
      PH_CLOSE:    phase_d = PH_IDLE;
      default:     phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      is_st_q  <= 1'b0;
      first_q  <= 1'b0;
      ld_vld_q <= 1'b0;
      st_vld_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      first_q  <= (phase_q == PH_IDLE) && req;
      ld_vld_q <= ld_vld;
      st_vld_q <= st_vld;
      if (phase_q == PH_IDLE && req) is_st_q <= st_req;
    end
  end

  p_close_exit_r4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_CLOSE) |=> (phase_q == PH_IDLE));
  p_store_close_r4: assert property (@(posedge clk) disable iff (rst)
    ((phase_q == PH_ACKED) && is_st_q && st_vld) |=> (phase_q == PH_CLOSE));
endmodule

// File: rtl/ldst_addr_watch.sv
module ldst_addr_watch #(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              addr_vld,
  input  logic [ADDR_W-1:0] addr,
  output logic              hold_bad
);
  logic              armed_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      armed_q <= busy & addr_vld;
      addr_q  <= addr;
    end
  end

  assign hold_bad = armed_q && busy && (!addr_vld || (addr != addr_q));
endmodule

// File: rtl/ldst_err_latch.sv
module ldst_err_latch #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] viol,
  output logic         err,
  output logic [N-1:0] err_code
);
  logic [N-1:0] lowest;
  assign lowest = viol & (~viol + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      err      <= 1'b0;
      err_code <= '0;
    end else if (!err && (viol != '0)) begin
      err      <= 1'b1;
      err_code <= lowest;
    end
  end

  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    err |=> (err && $stable(err_code)));
  p_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(err_code));
endmodule

// File: rtl/ldst_port_checker.sv
module ldst_port_checker
  import ldst_chk_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld_req,
  input  logic                 st_req,
  input  logic                 busy,
  input  logic                 addr_vld,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 addr_ack,
  input  logic                 addr_exc,
  input  logic                 ld_vld,
  input  logic                 st_vld,
  output logic                 err,
  output logic [NUM_RULES-1:0] err_code
);
  logic [NUM_RULES-1:0] viol_fsm;
  logic [NUM_RULES-1:0] viol_all;
  logic                 hold_bad;

  ldst_phase_tracker u_phase (
    .clk(clk), .rst(rst), .ld_req(ld_req), .st_req(st_req), .busy(busy),
    .addr_ack(addr_ack), .addr_exc(addr_exc), .ld_vld(ld_vld),
    .st_vld(st_vld), .viol(viol_fsm)
  );

  ldst_addr_watch #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .busy(busy), .addr_vld(addr_vld), .addr(addr),
    .hold_bad(hold_bad)
  );

  always_comb begin
    viol_all = viol_fsm;
    viol_all[RB_ADDR] = hold_bad;
  end

  ldst_err_latch #(.N(NUM_RULES)) u_err (
    .clk(clk), .rst(rst), .viol(viol_all), .err(err), .err_code(err_code)
  );

  p_req_excl_r1: assert property (@(posedge clk) disable iff (rst)
    (ld_req && st_req) |=> err);
  p_req_busy_r2: assert property (@(posedge clk) disable iff (rst)
    ((ld_req || st_req) && busy) |=> err);
  p_answer_excl_r6: assert property (@(posedge clk) disable iff (rst)
    (addr_ack && addr_exc) |=> err);
  p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (ld_vld && $past(ld_vld)) |=> err);
endmodule

// File: tb/ldst_port_checker_tb.sv
module ldst_port_checker_tb_top;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_req = 0, st_req = 0, busy = 0, addr_vld = 0;
  logic [AW-1:0] addr = '0;
  logic          addr_ack = 0, addr_exc = 0, ld_vld = 0, st_vld = 0;
  logic          err;
  logic [8:0]    err_code;
  int            checks = 0;
  int            fails = 0;
  bit            done = 0;

  always #5 clk = ~clk;

  ldst_port_checker #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .ld_req(ld_req), .st_req(st_req), .busy(busy),
    .addr_vld(addr_vld), .addr(addr), .addr_ack(addr_ack),
    .addr_exc(addr_exc), .ld_vld(ld_vld), .st_vld(st_vld),
    .err(err), .err_code(err_code)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    ld_req = 0; st_req = 0; busy = 0; addr_vld = 0; addr = '0;
    addr_ack = 0; addr_exc = 0; ld_vld = 0; st_vld = 0;
  endtask

  task automatic do_reset();
    quiet();
    rst = 1; tick(); tick();
    rst = 0;
  endtask

  task automatic chk(input string rq, input logic [8:0] exp);
    checks++;
    if (err !== (exp != 0) || err_code !== exp) begin
      fails++;
      $display("FAIL %s: err=%0b code=%b expected err=%0b code=%b",
               rq, err, err_code, (exp != 0), exp);
    end
  endtask

  // request, then busy with a valid address, then one step more
  task automatic open_txn(input bit store);
    ld_req = !store; st_req = store; tick();
    ld_req = 0; st_req = 0; busy = 1; addr_vld = 1; addr = 16'h1234; tick();
  endtask

  task automatic t_reset();
    do_reset(); chk("R10 reset", 9'b0);
  endtask

  task automatic t_clean();
    do_reset(); open_txn(0);
    addr_ack = 1; tick(); addr_ack = 0; tick();
    ld_vld = 1; busy = 0; tick(); quiet(); tick();
    chk("R11 clean load", 9'b0);
    open_txn(1);
    addr_ack = 1; tick(); addr_ack = 0;
    st_vld = 1; tick(); st_vld = 0; busy = 0; tick(); quiet(); tick();
    chk("R11 clean store", 9'b0);
    open_txn(0);
    addr_exc = 1; busy = 0; tick(); quiet(); tick();
    chk("R11 clean exception", 9'b0);
  endtask

  task automatic t_r1();
    do_reset(); ld_req = 1; st_req = 1; tick(); quiet();
    chk("R1 both strobes", 9'b000000001);
  endtask

  task automatic t_r2();
    do_reset(); open_txn(0); ld_req = 1; tick();
    chk("R2 request while busy", 9'b000000010);
  endtask

  task automatic t_r3();
    do_reset(); ld_req = 1; tick(); ld_req = 0; tick();
    chk("R3 busy late", 9'b000000100);
    do_reset(); busy = 1; tick();
    chk("R3 busy without request", 9'b000000100);
  endtask

  task automatic t_r4();
    do_reset(); open_txn(0); addr_exc = 1; tick();
    chk("R4 busy kept at exception", 9'b000001000);
    do_reset(); open_txn(1); addr_ack = 1; tick(); addr_ack = 0;
    st_vld = 1; tick(); st_vld = 0;
    chk("R4 store pulse cycle clean", 9'b0);
    tick();
    chk("R4 busy kept after store pulse", 9'b000001000);
    do_reset(); open_txn(0); addr_ack = 1; tick(); addr_ack = 0;
    busy = 0; tick();
    chk("R4 busy fell with no load data", 9'b000001000);
  endtask

  task automatic t_r5();
    do_reset(); open_txn(0); addr = 16'h1235; tick();
    chk("R5 address changed", 9'b000010000);
    do_reset(); open_txn(1); addr_vld = 0; tick();
    chk("R5 address valid dropped", 9'b000010000);
  endtask

  task automatic t_r6();
    do_reset(); open_txn(0); addr_ack = 1; tick(); tick();
    chk("R6 accept held two cycles", 9'b000100000);
    do_reset(); open_txn(0); addr_ack = 1; addr_exc = 1; busy = 0; tick();
    chk("R6 accept with exception", 9'b000100000);
  endtask

  task automatic t_r7();
    do_reset(); open_txn(0); addr_ack = 1; tick(); addr_ack = 0;
    ld_vld = 1; busy = 0; tick(); tick();
    chk("R7 load valid two cycles", 9'b001000000);
  endtask

  task automatic t_r8();
    do_reset(); open_txn(1); st_vld = 1; tick();
    chk("R8 store data before accept", 9'b010000000);
  endtask

  task automatic t_r9();
    do_reset(); open_txn(0); addr_ack = 1; tick(); addr_ack = 0;
    st_vld = 1; tick();
    chk("R9 store valid in load", 9'b100000000);
    do_reset(); ld_vld = 1; tick();
    chk("R9 load valid while idle", 9'b100000000);
  endtask

  task automatic t_r10();
    do_reset(); open_txn(0); addr = 16'h0001; tick();
    ld_req = 1; st_req = 1; tick(); quiet(); tick();
    chk("R10 first breach kept", 9'b000010000);
    do_reset(); busy = 1; ld_req = 1; st_req = 1; tick();
    chk("R10 lowest bit wins", 9'b000000001);
    do_reset();
    chk("R10 reset clears", 9'b0);
  endtask

  initial begin
    t_reset(); t_clean(); t_r1(); t_r2(); t_r3(); t_r4(); t_r5();
    t_r6(); t_r7(); t_r8(); t_r9(); t_r10();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule